// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM and walks the memory from power-on to a usable state. After reset it drives a no-operation command while it counts a start-up wait, expressed in clock cycles as the product of the clock rate in MHz and the wait in microseconds. For that whole wait it holds clock enable and every data mask line high, so the data bus cannot be driven from both sides.

When the wait expires the sequencer issues one precharge to all banks. It then issues a mode register load carrying the caller's mode word and a set number of auto-refresh commands. A parameter decides whether the refreshes come before or after the mode load. Every command is followed by a parameterized run of no-operation cycles, which covers the precharge period, the refresh cycle time and the mode load settling time. Once the last gap has elapsed the done flag rises and stays high. From then on the block drives only no-operation commands and releases the data masks, and the normal memory controller takes over.

The state machine has eight states. PAUSE goes to PRECH when the timer expires. PRECH goes to PRECH_GAP at once. PRECH_GAP goes to REFR (refresh-first) or MODE (mode-first) when the timer expires. REFR goes to REFR_GAP at once. REFR_GAP goes back to REFR until the refresh tally is reached, then to MODE (refresh-first) or READY (mode-first). MODE goes to MODE_GAP at once. MODE_GAP goes to READY (refresh-first) or REFR (mode-first) when the timer expires. READY holds until reset.

Top module: `sdram_boot_seq`

## Requirements
- R1: From reset until PAUSE_CYCLES = CLK_MHZ*PAUSE_US cycles after reset release, the command {cs_n,ras_n,cas_n,we_n} is the no-operation code 4'b0111.
- R2: cke is high from reset onward. All dqm bits are high from reset until init_done rises and low from then on.
- R3: The first command other than no-operation is a precharge-all, code 4'b0010. It appears in cycle PAUSE_CYCLES after reset release, with address bit PALL_BIT (default 10) set and every other address bit clear.
- R4: The mode register load is code 4'b0000, and the address bus equals mode_word in that cycle. It comes only after the precharge-all.
- R5: Exactly REFRESH_COUNT (default 8) auto-refresh commands, code 4'b0001 with address zero, are issued. With REFRESH_FIRST=1 they all come before the mode register load; with REFRESH_FIRST=0 they all come after it.
- R6: The mode register load is followed by exactly MODE_GAP (at least 1) no-operation cycles before the next command or before done.
- R7: A precharge is followed by exactly PRECH_GAP no-operation cycles and each refresh by exactly REFR_GAP no-operation cycles. The next command is issued in the cycle right after that gap.
- R8: init_done rises in the cycle after the last gap ends and stays high until reset. The command stays no-operation while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the whole sequence |
| mode_word | input | ADDR_W | Value placed on the address bus during the mode register load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Memory address bus |
| cke | output | 1 | Clock enable to the memory |
| dqm | output | DQM_W | Data mask lines |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The bench builds two copies of the block side by side. The first uses the defaults: a 200 us wait at 125 MHz (25,000 cycles), refreshes after the mode load, and multi-cycle gaps. This checks the full-length pause count and the mode-first ordering. The second uses a 1 us wait, one-cycle gaps and refresh-first ordering. This reaches the other placement branch and the shortest legal spacing, where any off-by-one in the gap timer moves a command by a visible cycle. Each copy receives a different mode word, so the address bus is checked for real content in the mode load cycle.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    // Command code packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP  = 4'b0111,
        CMD_PALL = 4'b0010,
        CMD_AREF = 4'b0001,
        CMD_MLOAD = 4'b0000
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECH,
        ST_PRECH_GAP,
        ST_REFR,
        ST_REFR_GAP,
        ST_MODE,
        ST_MODE_GAP,
        ST_READY
    } boot_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/boot_refresh_tally.sv
module boot_refresh_tally #(
    parameter int TARGET = 8,
    localparam int CW    = $clog2(TARGET + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump,
    output logic reached
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bump && !reached) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q >= CW'(TARGET));

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CLK_MHZ       = 125,
    parameter int PAUSE_US      = 200,
    parameter int PRECH_GAP     = 3,
    parameter int REFR_GAP      = 9,
    parameter int MODE_GAP      = 2,
    parameter int REFRESH_COUNT = 8,
    parameter bit REFRESH_FIRST = 1'b0,
    parameter int ADDR_W        = 13,
    parameter int DQM_W         = 2,
    parameter int PALL_BIT      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic              init_done
);

    localparam int PAUSE_CYCLES = CLK_MHZ * PAUSE_US;
    localparam int MAX_WAIT = max2(max2(PAUSE_CYCLES, PRECH_GAP), max2(REFR_GAP, MODE_GAP));
    localparam int TW = $clog2(MAX_WAIT + 1);

    boot_state_e state_q, state_d;
    logic        tmr_load;
    logic [TW-1:0] tmr_val;
    logic        tmr_expired;
    logic        ref_bump;
    logic        ref_reached;
    sdram_cmd_e  cmd;

    boot_gap_timer #(
        .W       (TW),
        .RST_VAL (PAUSE_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    boot_refresh_tally #(
        .TARGET (REFRESH_COUNT)
    ) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump    (ref_bump),
        .reached (ref_reached)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PAUSE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_bump = 1'b0;
        unique case (state_q)
            ST_PAUSE: begin
                if (tmr_expired) state_d = ST_PRECH;
            end
            ST_PRECH: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(PRECH_GAP - 1);
                state_d  = ST_PRECH_GAP;
            end
            ST_PRECH_GAP: begin
                if (tmr_expired) state_d = REFRESH_FIRST ? ST_REFR : ST_MODE;
            end
            ST_REFR: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(REFR_GAP - 1);
                ref_bump = 1'b1;
                state_d  = ST_REFR_GAP;
            end
            ST_REFR_GAP: begin
                if (tmr_expired) begin
                    if (!ref_reached)      state_d = ST_REFR;
                    else if (REFRESH_FIRST) state_d = ST_MODE;
                    else                    state_d = ST_READY;
                end
            end
            ST_MODE: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(MODE_GAP - 1);
                state_d  = ST_MODE_GAP;
            end
            ST_MODE_GAP: begin
                if (tmr_expired) state_d = REFRESH_FIRST ? ST_READY : ST_REFR;
            end
            ST_READY: begin
                state_d = ST_READY;
            end
        endcase
    end

    // Pin outputs decoded from the state
    always_comb begin
        cmd       = CMD_NOP;
        addr      = '0;
        init_done = 1'b0;
        unique case (state_q)
            ST_PRECH: begin
                cmd  = CMD_PALL;
                addr = ADDR_W'(1) << PALL_BIT;
            end
            ST_REFR:  cmd = CMD_AREF;
            ST_MODE: begin
                cmd  = CMD_MLOAD;
                addr = mode_word;
            end
            ST_READY: init_done = 1'b1;
            ST_PAUSE, ST_PRECH_GAP, ST_REFR_GAP, ST_MODE_GAP: cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke = 1'b1;
    assign dqm = init_done ? '0 : '1;

endmodule

// File: rtl/sdram_boot_checker.sv
module sdram_boot_checker #(
    parameter int CLK_MHZ       = 125,
    parameter int PAUSE_US      = 200,
    parameter int REFRESH_COUNT = 8,
    parameter bit REFRESH_FIRST = 1'b0,
    parameter int ADDR_W        = 13,
    parameter int DQM_W         = 2,
    parameter int PALL_BIT      = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mode_word,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cke,
    input logic [DQM_W-1:0]  dqm,
    input logic              init_done
);

    localparam int PAUSE_CYCLES = CLK_MHZ * PAUSE_US;
    localparam int CW = $clog2(PAUSE_CYCLES + 1);

    logic [3:0]    cmd;
    logic [CW-1:0] since_rst;
    logic [15:0]   refs_seen;
    logic          pall_seen;
    logic          mload_seen;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst  <= '0;
            refs_seen  <= '0;
            pall_seen  <= 1'b0;
            mload_seen <= 1'b0;
        end else begin
            if (since_rst != CW'(PAUSE_CYCLES)) since_rst <= since_rst + 1'b1;
            if (cmd == 4'b0001 && refs_seen != 16'hFFFF) refs_seen <= refs_seen + 1'b1;
            if (cmd == 4'b0010) pall_seen <= 1'b1;
            if (cmd == 4'b0000) mload_seen <= 1'b1;
        end
    end

    assert_pause_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(PAUSE_CYCLES)) |-> (cmd == 4'b0111));

    assert_pause_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(PAUSE_CYCLES)) |-> (cke && (&dqm)));

    assert_cke_high_R2: assert property (@(posedge clk) disable iff (!rst_n) cke);

    assert_pall_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |-> addr[PALL_BIT]);

    assert_mload_after_pall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (pall_seen && addr == mode_word));

    assert_refresh_place_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |-> (REFRESH_FIRST ? (refs_seen == 16'(REFRESH_COUNT)) : (refs_seen == '0)));

    assert_refresh_after_pall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |-> pall_seen);

    assert_mload_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000) |=> (cmd == 4'b0111));

    assert_pall_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010) |=> (cmd == 4'b0111));

    assert_refresh_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001) |=> (cmd == 4'b0111));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_complete_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (mload_seen && refs_seen == 16'(REFRESH_COUNT) && cmd == 4'b0111 && dqm == '0));

endmodule

bind sdram_boot_seq sdram_boot_checker #(
    .CLK_MHZ       (CLK_MHZ),
    .PAUSE_US      (PAUSE_US),
    .REFRESH_COUNT (REFRESH_COUNT),
    .REFRESH_FIRST (REFRESH_FIRST),
    .ADDR_W        (ADDR_W),
    .DQM_W         (DQM_W),
    .PALL_BIT      (PALL_BIT)
) u_boot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_word (mode_word),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .cke       (cke),
    .dqm       (dqm),
    .init_done (init_done)
);

// File: tb/test_sdram_boot_seq.sv
module boot_lane #(
    parameter int          PAUSE_US = 200,
    parameter int          TRP      = 3,
    parameter int          TRC      = 9,
    parameter int          TMRD     = 2,
    parameter bit          RF       = 1'b0,
    parameter logic [12:0] MODE     = 13'h0032,
    parameter string       TAG      = "A"
) (
    input  logic clk,
    output int   n_chk,
    output int   n_bad,
    output logic fin
);
    localparam int CLK_MHZ = 125;
    localparam int P       = CLK_MHZ * PAUSE_US;
    localparam int NREF    = 8;
    localparam int AW      = 13;
    localparam int DW      = 2;
    localparam int PALL    = 10;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [AW-1:0] adr;
    } exp_t;

    exp_t sbq[$];
    int   done_cyc;

    logic          rst_n;
    logic [AW-1:0] mode_word;
    logic          cs_n, ras_n, cas_n, we_n, cke, init_done;
    logic [AW-1:0] addr;
    logic [DW-1:0] dqm;

    sdram_boot_seq #(
        .CLK_MHZ       (CLK_MHZ),
        .PAUSE_US      (PAUSE_US),
        .PRECH_GAP     (TRP),
        .REFR_GAP      (TRC),
        .MODE_GAP      (TMRD),
        .REFRESH_COUNT (NREF),
        .REFRESH_FIRST (RF),
        .ADDR_W        (AW),
        .DQM_W         (DW),
        .PALL_BIT      (PALL)
    ) i_sdram_boot_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_word (mode_word),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .cke       (cke),
        .dqm       (dqm),
        .init_done (init_done)
    );

    task automatic push(input int c, input logic [3:0] k, input logic [AW-1:0] a);
        exp_t e;
        e.cyc = c;
        e.cmd = k;
        e.adr = a;
        sbq.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s lane %s %s: actual=%0h expected=%0h", req, TAG, what, act, exp);
        end
    endtask

    // Driver: builds the expected command list from the requirements
    initial begin
        int t;
        rst_n     = 1'b0;
        mode_word = MODE;
        t = P;
        push(t, C_PRE, AW'(1) << PALL);         // R3
        t += 1 + TRP;                           // R7
        if (RF) begin
            for (int i = 0; i < NREF; i++) begin
                push(t, C_REF, '0);             // R5
                t += 1 + TRC;
            end
            push(t, C_MRS, MODE);               // R4
            t += 1 + TMRD;                      // R6
        end else begin
            push(t, C_MRS, MODE);
            t += 1 + TMRD;
            for (int i = 0; i < NREF; i++) begin
                push(t, C_REF, '0);
                t += 1 + TRC;
            end
        end
        done_cyc = t;                           // R8
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    end

    // Monitor: pops expected commands and compares at the pins
    initial begin
        int k;
        logic [3:0] cmd;
        logic [3:0] prev;
        exp_t e;
        n_chk = 0;
        n_bad = 0;
        fin   = 1'b0;
        prev  = C_NOP;
        @(negedge clk);
        cmd = {cs_n, ras_n, cas_n, we_n};
        check(cmd == C_NOP, "R1", "reset cmd", int'(cmd), int'(C_NOP));
        check(cke == 1'b1, "R2", "reset cke", int'(cke), 1);
        check(dqm == '1, "R2", "reset dqm", int'(dqm), 3);
        check(init_done == 1'b0, "R8", "reset done", int'(init_done), 0);
        wait (rst_n);
        #1;
        k = 0;
        forever begin
            cmd = {cs_n, ras_n, cas_n, we_n};
            if (k < P) begin
                check(cmd == C_NOP, "R1", "pause cmd", int'(cmd), int'(C_NOP));
            end else if (cmd != C_NOP) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R8", "command after sequence", int'(cmd), int'(C_NOP));
                end else begin
                    e = sbq.pop_front();
                    if (prev == C_NOP)
                        check(e.cyc == k, "R3", "precharge cycle", k, e.cyc);
                    else if (prev == C_MRS)
                        check(e.cyc == k, "R6", "cycle after mode load", k, e.cyc);
                    else
                        check(e.cyc == k, "R7", "cycle after gap", k, e.cyc);
                    if (e.cmd == C_MRS)
                        check(cmd == e.cmd, "R4", "mode load code", int'(cmd), int'(e.cmd));
                    else
                        check(cmd == e.cmd, "R5", "command order", int'(cmd), int'(e.cmd));
                    check(addr == e.adr, "R4", "address", int'(addr), int'(e.adr));
                    prev = cmd;
                end
            end else if (sbq.size() != 0 && sbq[0].cyc == k) begin
                check(1'b0, "R7", "missing command", int'(cmd), int'(sbq[0].cmd));
            end
            check(cke == 1'b1, "R2", "cke", int'(cke), 1);
            check(dqm == ((k >= done_cyc) ? 2'b00 : 2'b11), "R2", "dqm",
                  int'(dqm), (k >= done_cyc) ? 0 : 3);
            check(init_done == (k >= done_cyc), "R8", "done", int'(init_done),
                  int'(k >= done_cyc));
            if (k >= done_cyc + 16) break;
            @(negedge clk);
            k++;
        end
        check(sbq.size() == 0, "R5", "commands left unissued", sbq.size(), 0);
        fin = 1'b1;
    end
endmodule

module test_sdram_boot_seq;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    int   chk_a, bad_a, chk_b, bad_b;
    logic fin_a, fin_b;

    boot_lane #(
        .PAUSE_US (200), .TRP (3), .TRC (9), .TMRD (2),
        .RF (1'b0), .MODE (13'h0032), .TAG ("mode-first")
    ) u_lane_a (.clk(clk), .n_chk(chk_a), .n_bad(bad_a), .fin(fin_a));

    boot_lane #(
        .PAUSE_US (1), .TRP (1), .TRC (1), .TMRD (1),
        .RF (1'b1), .MODE (13'h1A27), .TAG ("refresh-first")
    ) u_lane_b (.clk(clk), .n_chk(chk_b), .n_bad(bad_b), .fin(fin_b));

    initial begin
        int cyc;
        int extra;
        cyc   = 0;
        extra = 0;
        while (!(fin_a === 1'b1 && fin_b === 1'b1) && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        if (!(fin_a === 1'b1 && fin_b === 1'b1)) begin
            extra = 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==",
                 chk_a + chk_b + extra, bad_a + bad_b + extra);
        $finish;
    end
endmodule